// File: doc/BRIEF.md
# Two-way set associative read cache controller

This block sits between a processor's read port and a slower word-wide external memory. It keeps a small store of four-word lines organised as two ways per set. Each line carries a tag, a valid flag and a lock flag. A read that hits is answered from the store one cycle after it is issued. A read that misses refills a whole line from external memory. The refill starts with the requested word and wraps around within the line, and the processor is answered as soon as that first word comes back.

When the refill has to displace a line, it prefers an empty way. If both ways are full, it never takes a locked line. When both ways are free to replace, it picks one using bit 0 of a free-running 8-bit LFSR. A request can ask for the line it fills to be locked.

A privileged configuration write controls a disable flag. The flag is set on reset and cannot be cleared until a full invalidation has completed. While the flag is set, every read is a single-word external access that leaves the store untouched. The invalidate-all command walks the sets one per cycle. While it runs, a busy flag is raised and new reads are held off.

Top module: `cache2w_ctrl`

## Requirements
- R1: After reset, `cfg_disabled` is 1, `inval_busy` is 0, `cpu_ready` is 1 and `mem_req` is 0.
- R2: While `cfg_disabled` is 1, each read makes exactly one external word access at the requested address and returns that word. This holds even for an address that is held in the store, and nothing is allocated.
- R3: A configuration write or an invalidate request made with `supervisor` at 0 has no effect.
- R4: A write of 0 to the disable flag is ignored until an invalidate-all has completed since reset. A write of 1 always sets the flag.
- R5: An invalidate-all holds `inval_busy` high for exactly SETS cycles, with `cpu_ready` low throughout. Afterwards every line is invalid, so any read misses.
- R6: A read whose tag matches a valid line in either way of its set is acknowledged on the cycle after the request, with the stored word and no external access.
- R7: The address is word-based. Bits [1:0] select the word in the line, bits [IDX_W+1:2] select the set, and the remaining upper bits form the tag. A miss fetches four words in the order w, w+1, w+2, w+3 (mod 4), where w is the requested word. `cpu_ack` fires with the first word.
- R8: On a miss where one way of the set is empty, the empty way is filled, so the lines already held in that set stay resident.
- R9: On a miss where both ways are valid and unlocked, one of the two lines is replaced. The new line is then resident.
- R10: A line filled by a request with `cpu_lock` at 1 is never replaced by a later refill.
- R11: On a miss where both ways of the set are valid and locked, the read is served by a single external word access and no line is allocated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| supervisor | input | 1 | Privilege qualifier for configuration writes and invalidation |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_disable_wr | input | 1 | Value written to the disable flag |
| cfg_disabled | output | 1 | Current disable flag |
| inval_req | input | 1 | Invalidate-all request, taken while idle |
| inval_busy | output | 1 | High while invalidation walks the sets |
| cpu_req | input | 1 | One-cycle read request, taken when `cpu_ready` is high |
| cpu_addr | input | ADDR_W | Word address of the read |
| cpu_lock | input | 1 | Lock the line filled by this read |
| cpu_ready | output | 1 | Controller idle and able to take a request |
| cpu_ack | output | 1 | One-cycle pulse, read data valid |
| cpu_rdata | output | 32 | Read data |
| mem_req | output | 1 | External word request, held until acknowledged |
| mem_addr | output | ADDR_W | External word address |
| mem_ack | input | 1 | External word acknowledge with data |
| mem_rdata | input | 32 | External read data |

## Verification
The assertions assume that `cpu_req` is a single-cycle pulse given only while `cpu_ready` is high. They also assume that `mem_ack` appears only while `mem_req` is held, at most once per word. The bench meets both conditions. It issues every read from a task that waits for `cpu_ready`, and its memory model answers a pending request one cycle later and then drops its acknowledge for a cycle. The victim choice is pseudo-random, so the checks on replacement judge only outcomes that every legal choice leads to. Locked lines and empty ways make the outcome deterministic, and those cases are checked exactly.

// File: rtl/cache2w_pkg.sv
package cache2w_pkg;
    localparam int WORD_W     = 32;
    localparam int LINE_WORDS = 4;
    localparam int OFS_W      = $clog2(LINE_WORDS);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FILL,
        ST_BYPASS,
        ST_CLEAR
    } ctl_state_e;
endpackage

// File: rtl/cache2w_lfsr.sv
module cache2w_lfsr #(
    parameter logic [7:0] SEED = 8'h5B
) (
    input  logic clk,
    input  logic rst_n,
    output logic rnd_bit
);
    logic [7:0] state_d, state_q;

    always_comb begin
        state_d = {state_q[6:0], state_q[7] ^ state_q[5] ^ state_q[4] ^ state_q[3]};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= (SEED == 8'h00) ? 8'h01 : SEED;
        else        state_q <= state_d;
    end

    assign rnd_bit = state_q[0];

    // R9: the random source must never lock up in the all-zero state
    p_lfsr_alive_r9: assert property (@(posedge clk) disable iff (!rst_n) state_q != 8'h00);
endmodule

// File: rtl/cache2w_way.sv
module cache2w_way
    import cache2w_pkg::*;
#(
    parameter int SETS  = 8,
    parameter int TAG_W = 11,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [OFS_W-1:0]  rd_word,
    output logic [TAG_W-1:0]  rd_tag,
    output logic              rd_valid,
    output logic              rd_lock,
    output logic [WORD_W-1:0] rd_data,
    input  logic              data_we,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [OFS_W-1:0]  wr_word,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              meta_we,
    input  logic [TAG_W-1:0]  meta_tag,
    input  logic              meta_lock,
    input  logic              clr_we,
    input  logic [IDX_W-1:0]  clr_idx
);
    localparam int ENTRIES = SETS * LINE_WORDS;

    logic [TAG_W-1:0]  tag_q   [SETS];
    logic [WORD_W-1:0] data_q  [ENTRIES];
    logic [SETS-1:0]   valid_q;
    logic [SETS-1:0]   lock_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            lock_q  <= '0;
        end else if (clr_we) begin
            valid_q[clr_idx] <= 1'b0;
            lock_q[clr_idx]  <= 1'b0;
        end else if (meta_we) begin
            valid_q[wr_idx] <= 1'b1;
            lock_q[wr_idx]  <= meta_lock;
        end
    end

    always_ff @(posedge clk) begin
        if (meta_we) tag_q[wr_idx] <= meta_tag;
        if (data_we) data_q[{wr_idx, wr_word}] <= wr_data;
    end

    assign rd_tag   = tag_q[rd_idx];
    assign rd_valid = valid_q[rd_idx];
    assign rd_lock  = lock_q[rd_idx];
    assign rd_data  = data_q[{rd_idx, rd_word}];

    // R10: a valid locked line is never overwritten by a refill
    p_locked_kept_r10: assert property (@(posedge clk) disable iff (!rst_n)
        meta_we |-> !(valid_q[wr_idx] && lock_q[wr_idx]));
    // R5: clearing and refilling never happen in the same cycle
    p_clr_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(clr_we && (meta_we || data_we)));
endmodule

// File: rtl/cache2w_ctrl.sv
module cache2w_ctrl
    import cache2w_pkg::*;
#(
    parameter int         ADDR_W = 16,
    parameter int         SETS   = 8,
    parameter logic [7:0] SEED   = 8'h5B
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              supervisor,
    input  logic              cfg_we,
    input  logic              cfg_disable_wr,
    output logic              cfg_disabled,
    input  logic              inval_req,
    output logic              inval_busy,
    input  logic              cpu_req,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_lock,
    output logic              cpu_ready,
    output logic              cpu_ack,
    output logic [WORD_W-1:0] cpu_rdata,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ack,
    input  logic [WORD_W-1:0] mem_rdata
);
    localparam int IDX_W = $clog2(SETS);
    localparam int TAG_W = ADDR_W - IDX_W - OFS_W;
    localparam int WAYS  = 2;

    typedef struct packed {
        ctl_state_e        st;
        logic              dis;
        logic              cleaned;
        logic [IDX_W-1:0]  clr_idx;
        logic [1:0]        cnt;
        logic              way;
        logic              lock;
        logic              ack;
        logic [WORD_W-1:0] rdata;
        logic              mreq;
        logic [ADDR_W-1:0] maddr;
    } ctl_t;

    ctl_t q, d;

    // address fields
    logic [TAG_W-1:0] req_tag, fill_tag;
    logic [IDX_W-1:0] req_idx, fill_idx;
    logic [OFS_W-1:0] req_word, fill_word;
    assign req_tag   = cpu_addr[ADDR_W-1 -: TAG_W];
    assign req_idx   = cpu_addr[OFS_W +: IDX_W];
    assign req_word  = cpu_addr[OFS_W-1:0];
    assign fill_tag  = q.maddr[ADDR_W-1 -: TAG_W];
    assign fill_idx  = q.maddr[OFS_W +: IDX_W];
    assign fill_word = q.maddr[OFS_W-1:0];

    // way storage
    logic [TAG_W-1:0]  rd_tag   [WAYS];
    logic [WORD_W-1:0] rd_data  [WAYS];
    logic [WAYS-1:0]   rd_valid, rd_lock, hit;
    logic              data_we, meta_we, clr_we;
    logic              rnd_bit;

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        cache2w_way #(.SETS(SETS), .TAG_W(TAG_W)) u_way (
            .clk       (clk),
            .rst_n     (rst_n),
            .rd_idx    (req_idx),
            .rd_word   (req_word),
            .rd_tag    (rd_tag[w]),
            .rd_valid  (rd_valid[w]),
            .rd_lock   (rd_lock[w]),
            .rd_data   (rd_data[w]),
            .data_we   (data_we && (q.way == w[0])),
            .wr_idx    (fill_idx),
            .wr_word   (fill_word),
            .wr_data   (mem_rdata),
            .meta_we   (meta_we && (q.way == w[0])),
            .meta_tag  (fill_tag),
            .meta_lock (q.lock),
            .clr_we    (clr_we),
            .clr_idx   (q.clr_idx)
        );
        assign hit[w] = rd_valid[w] && (rd_tag[w] == req_tag);
    end

    cache2w_lfsr #(.SEED(SEED)) u_lfsr (
        .clk     (clk),
        .rst_n   (rst_n),
        .rnd_bit (rnd_bit)
    );

    // victim choice for a miss in the current set
    logic victim_way, victim_ok;
    always_comb begin
        victim_ok  = 1'b1;
        victim_way = 1'b0;
        if (!rd_valid[0])                    victim_way = 1'b0;
        else if (!rd_valid[1])               victim_way = 1'b1;
        else if (rd_lock[0] && rd_lock[1])   victim_ok  = 1'b0;
        else if (rd_lock[0])                 victim_way = 1'b1;
        else if (rd_lock[1])                 victim_way = 1'b0;
        else                                 victim_way = rnd_bit;
    end

    always_comb begin
        d       = q;
        d.ack   = 1'b0;
        data_we = 1'b0;
        meta_we = 1'b0;
        clr_we  = 1'b0;

        if (cfg_we && supervisor) begin
            if (cfg_disable_wr)  d.dis = 1'b1;
            else if (q.cleaned)  d.dis = 1'b0;
        end

        case (q.st)
            ST_IDLE: begin
                if (inval_req && supervisor) begin
                    d.st      = ST_CLEAR;
                    d.clr_idx = '0;
                end else if (cpu_req) begin
                    d.lock  = cpu_lock;
                    d.maddr = cpu_addr;
                    d.cnt   = '0;
                    if (!q.dis && (hit != '0)) begin
                        d.ack   = 1'b1;
                        d.rdata = hit[0] ? rd_data[0] : rd_data[1];
                    end else if (!q.dis && victim_ok) begin
                        d.st   = ST_FILL;
                        d.way  = victim_way;
                        d.mreq = 1'b1;
                    end else begin
                        d.st   = ST_BYPASS;
                        d.mreq = 1'b1;
                    end
                end
            end
            ST_FILL: begin
                if (mem_ack) begin
                    data_we = 1'b1;
                    if (q.cnt == 2'd0) begin
                        d.ack   = 1'b1;
                        d.rdata = mem_rdata;
                    end
                    if (q.cnt == 2'd3) begin
                        meta_we = 1'b1;
                        d.mreq  = 1'b0;
                        d.st    = ST_IDLE;
                    end else begin
                        d.cnt = q.cnt + 2'd1;
                        d.maddr[OFS_W-1:0] = fill_word + OFS_W'(1);
                    end
                end
            end
            ST_BYPASS: begin
                if (mem_ack) begin
                    d.ack   = 1'b1;
                    d.rdata = mem_rdata;
                    d.mreq  = 1'b0;
                    d.st    = ST_IDLE;
                end
            end
            ST_CLEAR: begin
                clr_we = 1'b1;
                if (q.clr_idx == IDX_W'(SETS - 1)) begin
                    d.st      = ST_IDLE;
                    d.cleaned = 1'b1;
                end else begin
                    d.clr_idx = q.clr_idx + IDX_W'(1);
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q         <= '0;
            q.st      <= ST_IDLE;
            q.dis     <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign cfg_disabled = q.dis;
    assign inval_busy   = (q.st == ST_CLEAR);
    assign cpu_ready    = (q.st == ST_IDLE);
    assign cpu_ack      = q.ack;
    assign cpu_rdata    = q.rdata;
    assign mem_req      = q.mreq;
    assign mem_addr     = q.maddr;

    // R4: the cache stays disabled until a full invalidation has completed
    p_enable_after_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !q.cleaned |-> cfg_disabled);
    // R3: unprivileged configuration writes leave the flag unchanged
    p_cfg_priv_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !supervisor) |=> $stable(cfg_disabled));
    // R3: unprivileged invalidate requests never start a clear
    p_inval_priv_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ready && inval_req && !supervisor) |=> !inval_busy);
    // R6: a hit makes no external access and answers next cycle
    p_hit_local_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ready && cpu_req && !inval_req && !cfg_disabled && (hit != '0)) |=> (!mem_req && cpu_ack));
    // R7: refill words advance by one and wrap inside the line
    p_fill_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_FILL && mem_ack && q.cnt != 2'd3) |=>
            (mem_addr[OFS_W-1:0] == $past(mem_addr[OFS_W-1:0]) + OFS_W'(1)) &&
            (mem_addr[ADDR_W-1:OFS_W] == $past(mem_addr[ADDR_W-1:OFS_W])));
    // R2: a disabled cache never allocates
    p_bypass_no_alloc_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_BYPASS) |-> !meta_we);
    // R5: busy ends only by finishing the walk
    p_clear_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(inval_busy) |-> q.cleaned);
endmodule

// File: tb/cache2w_ctrl_test.sv
module cache2w_ctrl_test;
    localparam int ADDR_W = 16;
    localparam int SETS   = 8;
    localparam int NV     = 18;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic supervisor = 1'b0, cfg_we = 1'b0, cfg_disable_wr = 1'b0, inval_req = 1'b0;
    logic cpu_req = 1'b0, cpu_lock = 1'b0;
    logic [ADDR_W-1:0] cpu_addr = '0;
    logic cfg_disabled, inval_busy, cpu_ready, cpu_ack, mem_req;
    logic [31:0] cpu_rdata, mem_rdata;
    logic [ADDR_W-1:0] mem_addr;
    logic mem_ack;

    always #10 clk = ~clk;

    cache2w_ctrl #(.ADDR_W(ADDR_W), .SETS(SETS)) uut (
        .clk(clk), .rst_n(rst_n), .supervisor(supervisor), .cfg_we(cfg_we),
        .cfg_disable_wr(cfg_disable_wr), .cfg_disabled(cfg_disabled),
        .inval_req(inval_req), .inval_busy(inval_busy), .cpu_req(cpu_req),
        .cpu_addr(cpu_addr), .cpu_lock(cpu_lock), .cpu_ready(cpu_ready),
        .cpu_ack(cpu_ack), .cpu_rdata(cpu_rdata), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    function automatic logic [31:0] mem_word(input logic [ADDR_W-1:0] a);
        return {16'hD00D, a} ^ 32'h0013_0000;
    endfunction

    // external memory model and fetch log
    int fetch_cnt = 0;
    logic [ADDR_W-1:0] fetch_log [256];
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
            mem_rdata <= '0;
        end else if (mem_req && !mem_ack) begin
            mem_ack <= 1'b1;
            mem_rdata <= mem_word(mem_addr);
        end else begin
            mem_ack <= 1'b0;
        end
        if (rst_n && mem_req && mem_ack) begin
            fetch_log[fetch_cnt % 256] <= mem_addr;
            fetch_cnt <= fetch_cnt + 1;
        end
    end

    int checks = 0, fails = 0, cycles = 0;
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            fails = fails + 1;
            $display("FAIL watchdog expired: actual %0d cycles expected fewer", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    int r_lat, r_at_ack, r_total, r_base;
    logic [31:0] r_data;
    task automatic do_read(input logic [ADDR_W-1:0] a, input logic lk);
        while (!cpu_ready) @(negedge clk);
        r_base = fetch_cnt;
        cpu_req = 1'b1; cpu_addr = a; cpu_lock = lk;
        @(negedge clk);
        cpu_req = 1'b0; cpu_lock = 1'b0;
        r_lat = 1;
        while (!cpu_ack) begin @(negedge clk); r_lat++; end
        r_data = cpu_rdata;
        r_at_ack = fetch_cnt - r_base;
        while (!cpu_ready) @(negedge clk);
        r_total = fetch_cnt - r_base;
    endtask

    task automatic cfg_write(input logic sup, input logic val);
        @(negedge clk);
        supervisor = sup; cfg_we = 1'b1; cfg_disable_wr = val;
        @(negedge clk);
        cfg_we = 1'b0; supervisor = 1'b0;
    endtask

    int busy_n, ready_bad;
    task automatic invalidate(input logic sup);
        while (!cpu_ready) @(negedge clk);
        supervisor = sup; inval_req = 1'b1;
        @(negedge clk);
        inval_req = 1'b0; supervisor = 1'b0;
        busy_n = 0; ready_bad = 0;
        while (inval_busy) begin
            busy_n++;
            if (cpu_ready) ready_bad++;
            @(negedge clk);
        end
    endtask

    // stimulus table: address {tag, set, word}, lock request, expected fetch count
    localparam logic [ADDR_W-1:0] V_ADDR [NV] = '{
        16'd38, 16'd36, 16'd71, 16'd37, 16'd68,            // set 1: R7 R6 R8 R8 R8
        16'd105, 16'd136, 16'd170, 16'd170, 16'd107, 16'd139, // set 2: R10 fills, R11 bypass
        16'd204, 16'd237, 16'd270, 16'd207, 16'd236, 16'd205, 16'd270 // set 3: R10 eviction
    };
    localparam logic V_LOCK [NV] = '{0,0,0,0,0, 1,1,0,0,0,0, 1,0,0,0,0,0,0};
    localparam int   V_FETCH [NV] = '{4,0,4,0,0, 4,4,1,1,0,0, 4,4,4,0,4,0,4};

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 disabled", cfg_disabled, 1);
        check("R1 busy", inval_busy, 0);
        check("R1 ready", cpu_ready, 1);
        check("R1 mem_req", mem_req, 0);

        // R4: enabling before invalidation is refused
        cfg_write(1'b1, 1'b0);
        check("R4 enable refused", cfg_disabled, 1);

        // R2: disabled read goes straight to memory
        do_read(16'd300, 1'b0);
        check("R2 fetches", r_total, 1);
        check("R2 data", r_data, mem_word(16'd300));
        check("R2 addr", fetch_log[r_base % 256], 16'd300);

        // R3: unprivileged invalidate and config write do nothing
        invalidate(1'b0);
        check("R3 inval ignored", busy_n, 0);
        // R5: privileged invalidate
        invalidate(1'b1);
        check("R5 busy cycles", busy_n, SETS);
        check("R5 ready low", ready_bad, 0);
        cfg_write(1'b0, 1'b0);
        check("R3 cfg ignored", cfg_disabled, 1);
        cfg_write(1'b1, 1'b0);
        check("R4 enable accepted", cfg_disabled, 0);

        // table walk: R6 R7 R8 R10 R11
        for (int i = 0; i < NV; i++) begin
            do_read(V_ADDR[i], V_LOCK[i]);
            check($sformatf("R6/R7 data row %0d", i), r_data, mem_word(V_ADDR[i]));
            check($sformatf("R8/R10/R11 fetches row %0d", i), r_total, V_FETCH[i]);
            if (V_FETCH[i] == 0) check($sformatf("R6 latency row %0d", i), r_lat, 1);
            if (V_FETCH[i] == 4) begin
                check($sformatf("R7 ack on first word row %0d", i), r_at_ack, 1);
                for (int k = 0; k < 4; k++)
                    check($sformatf("R7 wrap order row %0d word %0d", i, k),
                          fetch_log[(r_base + k) % 256],
                          {V_ADDR[i][ADDR_W-1:2], 2'(V_ADDR[i][1:0] + 2'(k))});
            end
            if (V_FETCH[i] == 1)
                check($sformatf("R11 single addr row %0d", i), fetch_log[r_base % 256], V_ADDR[i]);
        end

        // R9: three tags in set 4, both ways unlocked
        do_read(16'd48, 1'b0);   // tag 1
        do_read(16'd80, 1'b0);   // tag 2
        do_read(16'd112, 1'b0);  // tag 3 evicts one
        check("R9 third fill", r_total, 4);
        do_read(16'd113, 1'b0);
        check("R9 new line resident", r_total, 0);
        do_read(16'd49, 1'b0);
        if (r_total == 0) begin
            do_read(16'd81, 1'b0);
            check("R9 other line evicted", r_total, 4);
        end else begin
            check("R9 evicted line refilled", r_total, 4);
        end

        // R2: cached address still bypasses when disabled
        cfg_write(1'b1, 1'b1);
        check("R2 disable set", cfg_disabled, 1);
        do_read(16'd36, 1'b0);
        check("R2 bypass on held line", r_total, 1);
        check("R2 bypass data", r_data, mem_word(16'd36));
        do_read(16'd16, 1'b0);
        cfg_write(1'b1, 1'b0);
        check("R2 re-enable", cfg_disabled, 0);
        do_read(16'd16, 1'b0);
        check("R2 no allocation", r_total, 4);

        // R5: after invalidate everything misses, locks cleared
        invalidate(1'b1);
        check("R5 busy cycles again", busy_n, SETS);
        do_read(16'd36, 1'b0);
        check("R5 miss after clear", r_total, 4);
        do_read(16'd107, 1'b0);
        check("R5 locked line cleared", r_total, 4);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule